// File: doc/BRIEF.md
# Frame Error Statistics Counters

This block keeps three receive-side error tallies and lets a controller read them over a narrow 8-bit register port. One tally counts frames that failed the CRC check without a framing fault. One counts short frames, below the 64-byte minimum length. One counts long frames, above 1518 bytes. The receive path measures each frame and checks its CRC. For every frame it sends a single-cycle pulse on the matching event input, and each pulse adds one to its tally.

The two 16-bit tallies are read one byte at a time. Two reads go to the same address: the first returns the upper byte and the second returns the lower byte. The first read holds the tally still, so the two bytes belong to one value. The second read empties the tally. A pulse that arrives while the tally is held is remembered, and the tally restarts at one instead of zero, so no frame goes uncounted. The 8-bit tally is read in one access and is emptied by that read. Every tally stops at its all-ones value.

Top module: `frame_err_stats`

## Requirements
- R1: After reset every tally is zero and `rd_data` is 0x00.
- R2: A one-cycle pulse on `ev_crc`, `ev_runt` or `ev_big` adds exactly one to its own tally and leaves the other two unchanged, when that tally is neither held nor being read in that cycle.
- R3: The tallies saturate. The 16-bit tallies stop at 0xFFFF and the 8-bit tally stops at 0xFF, and further pulses leave them there.
- R4: Address map: 0 selects the CRC tally, 1 the runt tally and 2 the long-frame tally. Address 3 reads 0x00. `rd_data` takes the selected byte on the clock edge where `rd_en` is sampled high, and holds it until the next read.
- R5: Each 16-bit tally has its own byte-phase bit. The first read returns bits 15:8 and the next read of the same address returns bits 7:0. Reads of other addresses in between do not change that phase.
- R6: A 16-bit tally is held from its upper-byte read until its lower-byte read. Pulses in that window, including one in the same cycle as the upper-byte read, do not change the value, so the lower byte matches the upper byte read earlier.
- R7: After the lower-byte read, a 16-bit tally becomes 0 if no pulse arrived during the held window or in the lower-byte read cycle.
- R8: If one or more pulses arrived during the held window or in the lower-byte read cycle, the tally becomes 0x0001 after the lower-byte read, however many pulses there were.
- R9: The 8-bit tally is read in a single access that returns its full value. The tally then becomes 0, or 0x01 if a pulse arrives in the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_crc | input | 1 | One-cycle pulse: frame with CRC error and no framing error |
| ev_runt | input | 1 | One-cycle pulse: frame shorter than the minimum length |
| ev_big | input | 1 | One-cycle pulse: frame longer than the maximum length |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 2 | Read address (0 CRC, 1 runt, 2 long-frame, 3 none) |
| rd_data | output | 8 | Registered read byte |

## Verification
The assertions assume that each event input and `rd_en` are clean synchronous levels, sampled once per rising edge. They also assume that an upper-byte read of a tally is eventually followed by its lower-byte read. The saturation property assumes a full tally is not emptied by a read in that cycle. The stimulus applies every input on the falling edge and gives each read a one-cycle `rd_en` pulse. It always finishes an upper/lower read pair, and it drives pulses during the held window only through the read tasks, so the held-value and restart-at-one checks are reached in a known order.

// File: rtl/stat_pkg.sv
package stat_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned MAX_W  = 16;

  // Saturating increment of a value held in the low w bits of a 16-bit word
  function automatic logic [MAX_W-1:0] sat_step(input logic [MAX_W-1:0] v,
                                                input int unsigned w);
    logic [MAX_W:0] lim;
    lim = (17'd1 << w) - 17'd1;
    if (v == lim[MAX_W-1:0]) return v;
    return v + 16'd1;
  endfunction

  // Value a tally restarts from after a clearing read
  function automatic logic [MAX_W-1:0] restart_val(input logic missed);
    return missed ? 16'd1 : 16'd0;
  endfunction

endpackage

// File: rtl/stat_cnt.sv
module stat_cnt
  import stat_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev,
  input  logic          rd,
  output logic [W-1:0]  cnt_o,
  output logic [7:0]    byte_o,
  output logic          frozen_o,
  output logic          pend_o,
  output logic          rd_hi_o,
  output logic          rd_lo_o
);

  logic [W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  generate
    if (W > BYTE_W) begin : g_split
      logic        phase_q;
      logic        pend_q;
      logic [15:0] wide;

      assign wide     = 16'(cnt_q);
      assign rd_hi_o  = rd && !phase_q;
      assign rd_lo_o  = rd && phase_q;
      assign frozen_o = phase_q;
      assign pend_o   = pend_q;
      assign byte_o   = phase_q ? wide[7:0] : wide[15:8];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q   <= '0;
          phase_q <= 1'b0;
          pend_q  <= 1'b0;
        end else if (rd_lo_o) begin
          cnt_q   <= W'(restart_val(pend_q || ev));
          phase_q <= 1'b0;
          pend_q  <= 1'b0;
        end else if (rd_hi_o) begin
          phase_q <= 1'b1;
          if (ev) pend_q <= 1'b1;
        end else if (phase_q) begin
          if (ev) pend_q <= 1'b1;
        end else if (ev) begin
          cnt_q <= W'(sat_step(16'(cnt_q), W));
        end
      end
    end else begin : g_single
      assign rd_hi_o  = 1'b0;
      assign rd_lo_o  = rd;
      assign frozen_o = 1'b0;
      assign pend_o   = 1'b0;
      assign byte_o   = 8'(cnt_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (rd) begin
          cnt_q <= W'(restart_val(ev));
        end else if (ev) begin
          cnt_q <= W'(sat_step(16'(cnt_q), W));
        end
      end
    end
  endgenerate

endmodule

// File: rtl/stat_rdmux.sv
module stat_rdmux #(
  parameter int unsigned N      = 3,
  parameter int unsigned ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  input  logic [N-1:0][7:0]     bytes_i,
  output logic [N-1:0]          sel_o,
  output logic [7:0]            rd_data
);

  logic [7:0] pick;

  generate
    for (genvar i = 0; i < N; i++) begin : g_sel
      assign sel_o[i] = rd_en && (rd_addr == ADDR_W'(i));
    end
  endgenerate

  always_comb begin
    pick = 8'h00;
    for (int i = 0; i < N; i++) begin
      if (rd_addr == ADDR_W'(i)) pick = bytes_i[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= 8'h00;
    else if (rd_en) rd_data <= pick;
  end

endmodule

// File: rtl/frame_err_stats.sv
module frame_err_stats #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned RUNT_W = 16,
  parameter int unsigned BIG_W  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_crc,
  input  logic       ev_runt,
  input  logic       ev_big,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data
);

  localparam int unsigned NCNT   = 3;
  localparam int unsigned ADDR_W = 2;

  logic [NCNT-1:0]      sel;
  logic [NCNT-1:0][7:0] bytes;

  logic [CRC_W-1:0]  crc_cnt;
  logic              crc_frozen, crc_pend, crc_rd_hi, crc_rd_lo;
  logic [RUNT_W-1:0] runt_cnt;
  logic              runt_frozen, runt_pend, runt_rd_hi, runt_rd_lo;
  logic [BIG_W-1:0]  big_cnt;
  logic              big_frozen, big_pend, big_rd_hi, big_rd_lo;

  stat_cnt #(.W(CRC_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .ev(ev_crc), .rd(sel[0]),
    .cnt_o(crc_cnt), .byte_o(bytes[0]), .frozen_o(crc_frozen),
    .pend_o(crc_pend), .rd_hi_o(crc_rd_hi), .rd_lo_o(crc_rd_lo)
  );

  stat_cnt #(.W(RUNT_W)) u_runt (
    .clk(clk), .rst_n(rst_n), .ev(ev_runt), .rd(sel[1]),
    .cnt_o(runt_cnt), .byte_o(bytes[1]), .frozen_o(runt_frozen),
    .pend_o(runt_pend), .rd_hi_o(runt_rd_hi), .rd_lo_o(runt_rd_lo)
  );

  stat_cnt #(.W(BIG_W)) u_big (
    .clk(clk), .rst_n(rst_n), .ev(ev_big), .rd(sel[2]),
    .cnt_o(big_cnt), .byte_o(bytes[2]), .frozen_o(big_frozen),
    .pend_o(big_pend), .rd_hi_o(big_rd_hi), .rd_lo_o(big_rd_lo)
  );

  stat_rdmux #(.N(NCNT), .ADDR_W(ADDR_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .bytes_i(bytes), .sel_o(sel), .rd_data(rd_data)
  );

endmodule

// File: rtl/stat_chk.sv
module stat_chk #(
  parameter int unsigned CRC_W = 16,
  parameter int unsigned BIG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ev_crc,
  input logic             ev_big,
  input logic             rd_en,
  input logic [1:0]       rd_addr,
  input logic [7:0]       rd_data,
  input logic [CRC_W-1:0] crc_cnt,
  input logic             crc_frozen,
  input logic             crc_pend,
  input logic             crc_rd_hi,
  input logic             crc_rd_lo,
  input logic [BIG_W-1:0] big_cnt,
  input logic             big_rd_lo,
  input logic             runt_rd_hi,
  input logic             runt_rd_lo
);

  localparam logic [CRC_W-1:0] CRC_MAX = '1;
  localparam logic [BIG_W-1:0] BIG_MAX = '1;

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_crc && !crc_frozen && !crc_rd_hi && !crc_rd_lo && crc_cnt != CRC_MAX)
    |=> crc_cnt == $past(crc_cnt) + 1'b1);

  p_sat_crc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_cnt == CRC_MAX && !crc_rd_lo) |=> crc_cnt == CRC_MAX);

  p_sat_big_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (big_cnt == BIG_MAX && !big_rd_lo) |=> big_cnt == BIG_MAX);

  p_addr3_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == 2'd3) |=> rd_data == 8'h00);

  p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

  p_phase_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    crc_rd_hi |=> crc_frozen);

  p_phase_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_frozen && !crc_rd_lo) |=> crc_frozen);

  p_one_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({crc_rd_hi, crc_rd_lo, runt_rd_hi, runt_rd_lo, big_rd_lo}));

  p_frozen_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_frozen && !crc_rd_lo) |=> $stable(crc_cnt));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_rd_lo && !crc_pend && !ev_crc) |=> crc_cnt == '0);

  p_restart_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_rd_lo && (crc_pend || ev_crc)) |=> crc_cnt == CRC_W'(1));

  p_big_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    big_rd_lo |=> big_cnt == (ev_big ? BIG_W'(0) : BIG_W'(0)) + BIG_W'($past(ev_big)));

endmodule

bind frame_err_stats stat_chk #(.CRC_W(CRC_W), .BIG_W(BIG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_crc(ev_crc), .ev_big(ev_big),
  .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .crc_cnt(crc_cnt), .crc_frozen(crc_frozen), .crc_pend(crc_pend),
  .crc_rd_hi(crc_rd_hi), .crc_rd_lo(crc_rd_lo),
  .big_cnt(big_cnt), .big_rd_lo(big_rd_lo),
  .runt_rd_hi(runt_rd_hi), .runt_rd_lo(runt_rd_lo)
);

// File: tb/frame_err_stats_tb_top.sv
module frame_err_stats_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_crc = 1'b0, ev_runt = 1'b0, ev_big = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  frame_err_stats dut_i (
    .clk(clk), .rst_n(rst_n), .ev_crc(ev_crc), .ev_runt(ev_runt),
    .ev_big(ev_big), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // which: 0 crc, 1 runt, 2 big
  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ev_crc  = (which == 0);
      ev_runt = (which == 1);
      ev_big  = (which == 2);
    end
    @(negedge clk);
    ev_crc = 1'b0; ev_runt = 1'b0; ev_big = 1'b0;
  endtask

  // One read access, optionally with an event pulse on counter ev_which in the same cycle
  task automatic rd(input int addr, input int ev_which, output int data);
    @(negedge clk);
    rd_en   = 1'b1;
    rd_addr = 2'(addr);
    ev_crc  = (ev_which == 0);
    ev_runt = (ev_which == 1);
    ev_big  = (ev_which == 2);
    @(negedge clk);
    rd_en = 1'b0;
    ev_crc = 1'b0; ev_runt = 1'b0; ev_big = 1'b0;
    data = int'(rd_data);
  endtask

  task automatic rd16(input int addr, output int val);
    int hi, lo;
    rd(addr, -1, hi);
    rd(addr, -1, lo);
    val = (hi << 8) | lo;
  endtask

  initial begin
    int v, hi, lo, exp;
    repeat (3) @(negedge clk);
    check("R1 rd_data reset", int'(rd_data), 0);
    rst_n = 1'b1;
    rd16(0, v); check("R1 crc reset", v, 0);
    rd16(1, v); check("R1 runt reset", v, 0);
    rd(2, -1, v); check("R1 big reset", v, 0);

    // R2 / R7 sweep: n pulses then read back, expect n, then 0
    for (int n = 0; n <= 20; n++) begin
      pulse(n % 3, n);
      if (n % 3 == 2) rd(2, -1, v); else rd16(n % 3, v);
      check("R2 count sweep", v, n);
      if (n % 3 == 2) rd(2, -1, v); else rd16(n % 3, v);
      check("R7 cleared after read", v, 0);
    end

    // R2 independence: crc pulses leave others at zero
    pulse(0, 7);
    rd16(1, v); check("R2 runt untouched", v, 0);
    rd(2, -1, v); check("R2 big untouched", v, 0);
    rd16(0, v); check("R2 crc own count", v, 7);

    // R4 address 3 reads zero
    pulse(0, 4);
    rd(3, -1, v); check("R4 addr3 zero", v, 0);
    rd16(0, v); check("R4 addr0 crc", v, 4);

    // R3 saturation, 8-bit and 16-bit
    pulse(2, 300);
    rd(2, -1, v); check("R3 big saturates", v, 255);
    pulse(1, 65540);
    rd16(1, v); check("R3 runt saturates", v, 16'hFFFF);
    rd16(1, v); check("R7 runt cleared after sat", v, 0);

    // R5 interleaved reads keep per-counter phase
    pulse(0, 16'h0123 - 16'h0100 + 16'h0100);
    pulse(1, 16'h0245);
    rd(0, -1, hi);
    rd(1, -1, v); check("R5 runt high byte", v, 8'h02);
    rd(2, -1, v); check("R5 big between", v, 0);
    rd(1, -1, v); check("R5 runt low byte", v, 8'h45);
    rd(0, -1, lo);
    check("R5 crc high byte", hi, 8'h01);
    check("R5 crc low byte", lo, 8'h23);

    // R6 / R8: events in held window, including in the high-read cycle
    pulse(0, 16'h01FF);
    rd(0, 0, hi);
    pulse(0, 5);
    rd(0, -1, lo);
    check("R6 held value", (hi << 8) | lo, 16'h01FF);
    rd16(0, v); check("R8 restart at one", v, 1);
    rd16(0, v); check("R7 clear without pending", v, 0);

    // R8: single event only in the low-read cycle
    pulse(0, 3);
    rd(0, -1, hi);
    rd(0, 0, lo);
    check("R6 held value 2", (hi << 8) | lo, 3);
    rd16(0, v); check("R8 event at low read", v, 1);

    // R8: event only in the high-read cycle
    rd(0, 0, hi);
    rd(0, -1, lo);
    check("R6 empty held", (hi << 8) | lo, 0);
    rd16(0, v); check("R8 event at high read", v, 1);

    // R9: single-access big read, with event in the read cycle
    pulse(2, 9);
    rd(2, 2, v); check("R9 big value", v, 9);
    rd(2, -1, v); check("R9 big restart one", v, 1);
    rd(2, -1, v); check("R9 big cleared", v, 0);

    // R9 sweep of read-with-event over several counts
    for (int n = 1; n <= 6; n++) begin
      pulse(2, n);
      exp = n;
      rd(2, (n % 2 == 0) ? 2 : -1, v); check("R9 sweep value", v, exp);
      rd(2, -1, v); check("R9 sweep after", v, (n % 2 == 0) ? 1 : 0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule